// File: doc/BRIEF.md
# Multi-Mode Bidirectional I/O Port

This block is one eight-pin bidirectional port whose pins can each take their output value from several places. Software sets it up through four small registers: one per-pin mode select, one per-pin direction, a write-only output latch and a port-wide peripheral-bus enable. A pin can then carry the CPU's output latch, a bit of the low address byte, or the output of a programmable-logic array. In every one of those cases its output enable is the OR of the software direction bit and an enable term supplied per pin by that logic array.

Setting the peripheral-bus enable turns all pins into a data bus that links the CPU bus to an external device. The bus is active only while one of two select terms is true. A write strobe then drives the CPU's data onto the pins. A read strobe leaves the pins undriven and passes their levels back to the CPU bus. A CPU read of the data register returns the pad levels after they pass through a two-flop synchroniser.

Top module: `mio_port`

## Requirements
- R1: After reset, the mode-select, direction, output-latch and peripheral-enable registers are all 0. Every padOe bit is 0, and reads of register addresses 0, 1 and 3 return 0.
- R2: A write with regWrEn high stores regWrData on the next rising edge. Address 0 is mode select, 1 is direction, 2 is the output latch (write-only) and 3 is the peripheral enable. Only bit 7 of address 3 is kept, so a read of 3 returns bit 7 with the other bits 0. Reads of 0 and 1 return the stored value.
- R3: In CPU I/O mode (mode-select bit 0, pldOe bit 0), the pin outputs its output-latch bit, and a direction bit of 1 enables it as an output.
- R4: With the peripheral enable clear, padOe[i] equals dir[i] OR pldOe[i].
- R5: When a pin's mode-select bit and direction bit are both 1, padOut[i] is addrLow[i], whatever pldOe[i] is.
- R6: When address-out does not apply and pldOe[i] is 1, padOut[i] is pldOut[i]. This holds even when dir[i] is 1.
- R7: With the peripheral enable set, a select term (pselA or pselB) high, busWr high and busRd low, every padOe bit is 1 and padOut equals busDataOut.
- R8: With the peripheral enable set, a select term high and busRd high, padOe is 0 and busDataIn equals padIn. At all other times busDataIn is 0.
- R9: With the peripheral enable set, padOe is 0 and padOut is 0 whenever the port is not driving the bus: no select term, no write strobe, or both strobes high. This holds regardless of the direction bits and pldOe.
- R10: A read of address 2 returns the value padIn had two rising edges earlier. A change on padIn shows up after the second edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| addrLow | input | 8 | Low address byte for address-out pins |
| pldOut | input | 8 | Per-pin logic-array output values |
| pldOe | input | 8 | Per-pin logic-array output enables |
| pselA | input | 1 | Peripheral select term A |
| pselB | input | 1 | Peripheral select term B |
| busRd | input | 1 | Bus read strobe |
| busWr | input | 1 | Bus write strobe |
| busDataOut | input | 8 | CPU data to drive onto the pins |
| busDataIn | output | 8 | Pin levels passed to the CPU bus |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |

## Verification
The bench uses the default values PORT_W = 8 and SYNC_STAGES = 2. With PORT_W at 8, the peripheral-enable bit sits at bit 7, and one vector can mix address-out, logic-array and latch pins across different nibbles. With SYNC_STAGES at 2, the exact-cycle read-back check applies, so the bench can show that the first edge after a pad change still returns the old value and the second edge returns the new one.

// File: rtl/mio_pkg.sv
package mio_pkg;

  typedef enum logic [1:0] {
    REG_MODESEL = 2'd0,
    REG_DIR     = 2'd1,
    REG_DATA    = 2'd2,
    REG_PERIPH  = 2'd3
  } mioReg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic periphEn;   // port-wide peripheral bus mode
    logic busDrive;   // drive CPU data onto pins
    logic busSample;  // pass pin levels to CPU bus
  } mioStrobe_t;

endpackage

// File: rtl/mio_ctrl.sv
module mio_ctrl
  import mio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [PORT_W-1:0] regWrData,
  input  logic              pselA,
  input  logic              pselB,
  input  logic              busRd,
  input  logic              busWr,
  output logic [PORT_W-1:0] modeSel,
  output logic [PORT_W-1:0] dirReg,
  output logic [PORT_W-1:0] latchReg,
  output logic              periphBit,
  output mioStrobe_t        strobe
);

  localparam int PERIPH_BIT = PORT_W - 1;

  logic selected;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSel   <= '0;
      dirReg    <= '0;
      latchReg  <= '0;
      periphBit <= 1'b0;
    end else if (regWrEn) begin
      case (mioReg_t'(regAddr))
        REG_MODESEL: modeSel   <= regWrData;
        REG_DIR:     dirReg    <= regWrData;
        REG_DATA:    latchReg  <= regWrData;
        REG_PERIPH:  periphBit <= regWrData[PERIPH_BIT];
        default:     ;
      endcase
    end
  end

  always_comb begin
    selected         = pselA | pselB;
    strobe.periphEn  = periphBit;
    strobe.busDrive  = periphBit & selected & busWr & ~busRd;
    strobe.busSample = periphBit & selected & busRd;
  end

  // R2: a direction write lands on the next edge
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1) |=> (dirReg == $past(regWrData)));

  // R9: driving and sampling never coincide
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.busDrive, strobe.busSample}));

endmodule

// File: rtl/mio_datapath.sv
module mio_datapath
  import mio_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mioStrobe_t        strobe,
  input  logic [PORT_W-1:0] modeSel,
  input  logic [PORT_W-1:0] dirReg,
  input  logic [PORT_W-1:0] latchReg,
  input  logic              periphBit,
  input  logic [1:0]        regAddr,
  input  logic [PORT_W-1:0] addrLow,
  input  logic [PORT_W-1:0] pldOut,
  input  logic [PORT_W-1:0] pldOe,
  input  logic [PORT_W-1:0] busDataOut,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] busDataIn,
  output logic [PORT_W-1:0] regRdData
);

  localparam int PERIPH_BIT = PORT_W - 1;

  logic [PORT_W-1:0] pinVal;
  logic [PORT_W-1:0] pinOe;
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];

  // per-pin source select: address-out, then logic array, then latch
  genvar p;
  generate
    for (p = 0; p < PORT_W; p++) begin : g_pin
      always_comb begin
        pinOe[p] = dirReg[p] | pldOe[p];
        if (modeSel[p] && dirReg[p])
          pinVal[p] = addrLow[p];
        else if (pldOe[p])
          pinVal[p] = pldOut[p];
        else
          pinVal[p] = latchReg[p];
      end
    end
  endgenerate

  always_comb begin
    if (strobe.periphEn) begin
      padOe  = strobe.busDrive ? '1 : '0;
      padOut = strobe.busDrive ? busDataOut : '0;
    end else begin
      padOe  = pinOe;
      padOut = pinVal;
    end
    busDataIn = strobe.busSample ? padIn : '0;
  end

  // pad synchroniser
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN)
          syncQ[s] <= '0;
        else if (s == 0)
          syncQ[s] <= padIn;
        else
          syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    case (mioReg_t'(regAddr))
      REG_MODESEL: regRdData = modeSel;
      REG_DIR:     regRdData = dirReg;
      REG_DATA:    regRdData = syncQ[SYNC_STAGES-1];
      default: begin
        regRdData = '0;
        regRdData[PERIPH_BIT] = periphBit;
      end
    endcase
  end

  // ---------------- assertions ----------------
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R4: normal-mode enable follows direction OR logic term
  assert_oe_or_R4: assert property (@(posedge clk) disable iff (!rstN)
    !periphBit |-> (padOe == (dirReg | pldOe)));

  // R7: bus write drives every pin with CPU data
  assert_bus_drive_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busDrive |-> (padOe == {PORT_W{1'b1}} && padOut == busDataOut));

  // R8: bus read releases pins and forwards levels
  assert_bus_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busSample |-> (padOe == '0 && busDataIn == padIn));

  // R9: peripheral mode without a write leaves pins undriven
  assert_periph_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (periphBit && !strobe.busDrive) |-> (padOe == '0));

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      // R10: read-back lags the pads by exactly two edges
      assert_readback_lag_R10: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst >= 2'd2 && regAddr == 2'd2) |-> (regRdData == $past(padIn, 2)));
    end
  endgenerate

endmodule

// File: rtl/mio_port.sv
module mio_port
  import mio_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [PORT_W-1:0] regWrData,
  output logic [PORT_W-1:0] regRdData,
  input  logic [PORT_W-1:0] addrLow,
  input  logic [PORT_W-1:0] pldOut,
  input  logic [PORT_W-1:0] pldOe,
  input  logic              pselA,
  input  logic              pselB,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [PORT_W-1:0] busDataOut,
  output logic [PORT_W-1:0] busDataIn,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe
);

  mioStrobe_t        strobe;
  logic [PORT_W-1:0] modeSel;
  logic [PORT_W-1:0] dirReg;
  logic [PORT_W-1:0] latchReg;
  logic              periphBit;

  mio_ctrl #(.PORT_W(PORT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pselA(pselA), .pselB(pselB),
    .busRd(busRd), .busWr(busWr), .modeSel(modeSel), .dirReg(dirReg),
    .latchReg(latchReg), .periphBit(periphBit), .strobe(strobe)
  );

  mio_datapath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeSel(modeSel),
    .dirReg(dirReg), .latchReg(latchReg), .periphBit(periphBit),
    .regAddr(regAddr), .addrLow(addrLow), .pldOut(pldOut), .pldOe(pldOe),
    .busDataOut(busDataOut), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .busDataIn(busDataIn), .regRdData(regRdData)
  );

endmodule

// File: tb/mio_port_bench.sv
module mio_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  typedef struct packed {
    logic [7:0] req;
    logic [7:0] modeSel, dir, latch, periph, addr, pld, pldEn;
    logic [1:0] sel;
    logic       rd, wr;
    logic [7:0] bus, pad;
    logic [7:0] expOut, expOe, expBdi;
  } vec_t;

  // req  modeSel dir  latch periph addr pld  pldEn sel   rd wr  bus  pad  out  oe   bdi
  localparam vec_t VECS [NVEC] = '{
    '{8'd3,  8'h00,8'hF0,8'hA5,8'h00,8'h3C,8'h00,8'h00,2'b00,1'b0,1'b0,8'h00,8'h00,8'hA5,8'hF0,8'h00}, // R3
    '{8'd5,  8'hFF,8'h0F,8'hA5,8'h00,8'h3C,8'h00,8'h00,2'b00,1'b0,1'b0,8'h00,8'h00,8'hAC,8'h0F,8'h00}, // R5
    '{8'd6,  8'h00,8'h00,8'h00,8'h00,8'h00,8'h96,8'hF0,2'b00,1'b0,1'b0,8'h00,8'h00,8'h90,8'hF0,8'h00}, // R6
    '{8'd4,  8'h0F,8'h33,8'h00,8'h00,8'hFF,8'h00,8'h55,2'b00,1'b0,1'b0,8'h00,8'h00,8'h03,8'h77,8'h00}, // R4 R5 R6 mixed
    '{8'd7,  8'h00,8'h00,8'h00,8'h80,8'h00,8'h00,8'h00,2'b01,1'b0,1'b1,8'h5A,8'h00,8'h5A,8'hFF,8'h00}, // R7
    '{8'd8,  8'h00,8'hFF,8'h00,8'h80,8'h00,8'h00,8'hFF,2'b10,1'b1,1'b0,8'h00,8'hC3,8'h00,8'h00,8'hC3}, // R8
    '{8'd9,  8'h00,8'hFF,8'h00,8'h80,8'h00,8'h00,8'hFF,2'b00,1'b0,1'b1,8'h77,8'h00,8'h00,8'h00,8'h00}, // R9 no select
    '{8'd9,  8'h00,8'hFF,8'hFF,8'h80,8'h00,8'h00,8'h00,2'b01,1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00}, // R9 no strobe
    '{8'd9,  8'h00,8'h00,8'h00,8'h80,8'h00,8'h00,8'h00,2'b01,1'b1,1'b1,8'hEE,8'h11,8'h00,8'h00,8'h11}, // R9 both strobes
    '{8'd8,  8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,2'b01,1'b1,1'b0,8'h00,8'hFF,8'h00,8'h00,8'h00}, // R8 off-mode read
    '{8'd4,  8'h00,8'hFF,8'h3C,8'h00,8'h00,8'h00,8'h00,2'b01,1'b0,1'b1,8'h5A,8'h00,8'h3C,8'hFF,8'h00}  // R4 bus ignored
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData, regRdData, addrLow, pldOut, pldOe;
  logic       pselA, pselB, busRd, busWr;
  logic [7:0] busDataOut, busDataIn, padIn, padOut, padOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mio_port u_mio_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .addrLow(addrLow),
    .pldOut(pldOut), .pldOe(pldOe), .pselA(pselA), .pselB(pselB),
    .busRd(busRd), .busWr(busWr), .busDataOut(busDataOut),
    .busDataIn(busDataIn), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = '0;
    addrLow = '0; pldOut = '0; pldOe = '0; pselA = 1'b0; pselB = 1'b0;
    busRd = 1'b0; busWr = 1'b0; busDataOut = '0; padIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "padOe", padOe, 8'h00);
    regAddr = 2'd0; #1 check("R1", "modeSel read", regRdData, 8'h00);
    regAddr = 2'd1; #1 check("R1", "dir read", regRdData, 8'h00);
    regAddr = 2'd3; #1 check("R1", "periph read", regRdData, 8'h00);

    // R2: register writes and read-back
    wrReg(2'd0, 8'h6B); regAddr = 2'd0; #1 check("R2", "modeSel read", regRdData, 8'h6B);
    wrReg(2'd1, 8'hD2); regAddr = 2'd1; #1 check("R2", "dir read", regRdData, 8'hD2);
    wrReg(2'd3, 8'hFF); regAddr = 2'd3; #1 check("R2", "periph read", regRdData, 8'h80);
    wrReg(2'd3, 8'h7F); regAddr = 2'd3; #1 check("R2", "periph low bits", regRdData, 8'h00);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      wrReg(2'd0, VECS[i].modeSel);
      wrReg(2'd1, VECS[i].dir);
      wrReg(2'd2, VECS[i].latch);
      wrReg(2'd3, VECS[i].periph);
      addrLow = VECS[i].addr; pldOut = VECS[i].pld; pldOe = VECS[i].pldEn;
      pselA = VECS[i].sel[0]; pselB = VECS[i].sel[1];
      busRd = VECS[i].rd; busWr = VECS[i].wr;
      busDataOut = VECS[i].bus; padIn = VECS[i].pad;
      @(negedge clk);
      check(tag, $sformatf("vec%0d padOut", i), padOut, VECS[i].expOut);
      check(tag, $sformatf("vec%0d padOe", i), padOe, VECS[i].expOe);
      check(tag, $sformatf("vec%0d busDataIn", i), busDataIn, VECS[i].expBdi);
    end

    // R10: two-edge read-back latency
    pselA = 1'b0; pselB = 1'b0; busRd = 1'b0; busWr = 1'b0;
    wrReg(2'd3, 8'h00);
    padIn = 8'h00; regAddr = 2'd2;
    repeat (3) @(negedge clk);
    check("R10", "settled read", regRdData, 8'h00);
    padIn = 8'hA7;
    @(negedge clk);
    check("R10", "after first edge", regRdData, 8'h00);
    @(negedge clk);
    check("R10", "after second edge", regRdData, 8'hA7);

    // R1: reset mid-run clears configuration
    wrReg(2'd1, 8'hFF);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1; pldOe = '0;
    #1 check("R1", "padOe after reset", padOe, 8'h00);
    regAddr = 2'd1; #1 check("R1", "dir after reset", regRdData, 8'h00);

    finishRun();
  end

endmodule